// File: doc/BRIEF.md
# Strided Vector Load Unit over Interleaved Memory Banks

This block fetches one vector of words from a banked memory. A single start pulse supplies a base address, a stride and an element count. The unit then walks the address sequence base, base+stride, base+2·stride and so on, modulo the address space, and offers at most one address per cycle on a shared address bus. The target bank is chosen by the low address bits, so consecutive words lie in consecutive banks.

Each bank is a small synchronous array with a busy counter. Once a bank accepts an access, it cannot take another until its access latency has run out. When the next element maps to a busy bank, issue stalls in element order and no later element may go first. Each bank places its word on the shared return bus exactly one latency after issue, tagged with the element index. Returns therefore arrive in element order, at most one per cycle.

With unit stride and 16 banks against an 11-cycle latency, the unit sustains one element per cycle. A stride that keeps hitting one bank falls to one element per latency period. A one-cycle completion pulse follows the last returned word.

Top module: `stride_bank_loader`

## Requirements
- R1: After reset, busy_o, issue_valid_o, rd_valid_o and done_o are all low.
- R2: A start pulse seen while busy_o is low latches base, stride and length. Element i is issued at address (base + i·stride) mod 2^ADDR_W, and element 0 may issue in the cycle after the start pulse.
- R3: The bank of an address is its low BANK_W bits (bits 3:0 by default). A bank that accepts an access in cycle t accepts no other access before cycle t+LAT.
- R4: Each element issues in the earliest cycle that meets all three conditions: it is after the previous element's issue cycle, its bank is free, and it is no earlier than the cycle after start. As a result, stride 1 issues one element per cycle and stride 16 issues one element per LAT cycles.
- R5: The word for an element issued in cycle t appears with rd_valid_o high in cycle t+LAT. rd_idx_o carries the element index, returns come in increasing index order starting at 0, and at most one return occurs per cycle.
- R6: Memory word at address a holds (a·0x9E37 + 0x1234) mod 2^DATA_W after reset, and rd_data_o carries that word for the element's address.
- R7: done_o is high for exactly one cycle, the cycle after the last element's return. busy_o is low in that cycle, and no issue or return follows until the next start.
- R8: A start with length 0 issues nothing and raises done_o in the cycle after the start pulse.
- R9: A start pulse while busy_o is high is ignored: the running sequence of addresses, indices and timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| base_i | input | ADDR_W | First element address |
| stride_i | input | ADDR_W | Address step between elements (wraps) |
| vlen_i | input | VLEN_W | Number of elements |
| busy_o | output | 1 | A vector load is running |
| issue_valid_o | output | 1 | An access is placed on the shared address bus this cycle |
| issue_addr_o | output | ADDR_W | Address on the shared address bus |
| rd_valid_o | output | 1 | Returned word valid |
| rd_idx_o | output | VLEN_W | Element index of the returned word |
| rd_data_o | output | DATA_W | Returned word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every cycle, the assertions check four properties. No bank is reissued inside its latency window. Each issued address is the previous one plus the captured stride, with the first equal to the base. At most one bank drives the return bus, and returned indices step by one from zero. Completion is a single pulse that leaves the unit idle. Three things are shown only by the bench's sweeps over strides, bases and lengths: the exact stall schedule (one per cycle for unit stride, one per latency for same-bank strides, and mixed patterns between), the fixed issue-to-return latency with the stored data pattern, and that a start pulse during a run has no effect.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  // Next element address before truncation to the address width.
  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [31:0] s);
    return a + s;
  endfunction

  // Word held at an address after reset.
  function automatic logic [31:0] pattern_word(input logic [31:0] a);
    return a * 32'h0000_9E37 + 32'h0000_1234;
  endfunction
endpackage

// File: rtl/sbl_sequencer.sv
module sbl_sequencer #(
  parameter int ADDR_W = 10,
  parameter int VLEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VLEN_W-1:0] vlen_i,
  input  logic              bank_free_i,
  input  logic              rd_valid_i,
  input  logic [VLEN_W-1:0] rd_idx_i,
  output logic              active_o,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [VLEN_W-1:0] idx_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] stride_q;
  logic [VLEN_W-1:0] vlen_q, issued_q;
  logic              last_ret;

  assign fire_o   = active_o && (issued_q != vlen_q) && bank_free_i;
  assign idx_o    = issued_q;
  assign last_ret = rd_valid_i && (rd_idx_i == VLEN_W'(vlen_q - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      addr_o   <= '0;
      stride_q <= '0;
      vlen_q   <= '0;
      issued_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (!active_o && start_i) begin
        addr_o   <= base_i;
        stride_q <= stride_i;
        vlen_q   <= vlen_i;
        issued_q <= '0;
        if (vlen_i == '0) done_o <= 1'b1;
        else              active_o <= 1'b1;
      end else if (active_o) begin
        if (fire_o) begin
          addr_o   <= ADDR_W'(sbl_pkg::step_addr(32'(addr_o), 32'(stride_q)));
          issued_q <= issued_q + 1'b1;
        end
        if (last_ret) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbl_bank.sv
module sbl_bank #(
  parameter int ROW_W   = 6,
  parameter int BANK_W  = 4,
  parameter int DATA_W  = 16,
  parameter int VLEN_W  = 7,
  parameter int LAT     = 11,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [VLEN_W-1:0] idx_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] data_o,
  output logic [VLEN_W-1:0] idx_o
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem [ROWS];
  logic [CNT_W-1:0]  cnt_q;

  assign busy_o = (cnt_q != '0);
  assign fin_o  = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_o <= '0;
      idx_o  <= '0;
      for (int r = 0; r < ROWS; r++)
        mem[r] <= DATA_W'(sbl_pkg::pattern_word(32'((r << BANK_W) + BANK_ID)));
    end else if (sel_i) begin
      cnt_q  <= CNT_W'(LAT - 1);
      data_o <= mem[row_i];
      idx_o  <= idx_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sbl_return.sv
module sbl_return #(
  parameter int NB     = 16,
  parameter int DATA_W = 16,
  parameter int VLEN_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NB-1:0]                fin_i,
  input  logic [NB-1:0][DATA_W-1:0]    data_i,
  input  logic [NB-1:0][VLEN_W-1:0]    idx_i,
  output logic                         rd_valid_o,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic [VLEN_W-1:0]            rd_idx_o
);
  logic [DATA_W-1:0] data_sel;
  logic [VLEN_W-1:0] idx_sel;

  always_comb begin
    data_sel = '0;
    idx_sel  = '0;
    for (int b = 0; b < NB; b++) begin
      if (fin_i[b]) begin
        data_sel = data_sel | data_i[b];
        idx_sel  = idx_sel | idx_i[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_idx_o   <= '0;
    end else begin
      rd_valid_o <= |fin_i;
      rd_data_o  <= data_sel;
      rd_idx_o   <= idx_sel;
    end
  end
endmodule

// File: rtl/stride_bank_loader.sv
module stride_bank_loader #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int VLEN_W = 7,
  parameter int BANK_W = 4,
  parameter int LAT    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VLEN_W-1:0] vlen_i,
  output logic              busy_o,
  output logic              issue_valid_o,
  output logic [ADDR_W-1:0] issue_addr_o,
  output logic              rd_valid_o,
  output logic [VLEN_W-1:0] rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  localparam int NB    = 1 << BANK_W;
  localparam int ROW_W = ADDR_W - BANK_W;

  logic [NB-1:0]             bank_busy;
  logic [NB-1:0]             bank_fin;
  logic [NB-1:0][DATA_W-1:0] bank_data;
  logic [NB-1:0][VLEN_W-1:0] bank_idx;
  logic [BANK_W-1:0]         cur_bank;
  logic [ROW_W-1:0]          cur_row;
  logic [VLEN_W-1:0]         cur_idx;
  logic                      bank_free;
  logic                      fire;

  assign cur_bank      = issue_addr_o[BANK_W-1:0];
  assign cur_row       = issue_addr_o[ADDR_W-1:BANK_W];
  assign bank_free     = !bank_busy[cur_bank];
  assign issue_valid_o = fire;

  sbl_sequencer #(.ADDR_W(ADDR_W), .VLEN_W(VLEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .vlen_i(vlen_i), .bank_free_i(bank_free),
    .rd_valid_i(rd_valid_o), .rd_idx_i(rd_idx_o), .active_o(busy_o),
    .fire_o(fire), .addr_o(issue_addr_o), .idx_o(cur_idx), .done_o(done_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sbl_bank #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .VLEN_W(VLEN_W),
      .LAT(LAT), .BANK_ID(b)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .sel_i(fire && (cur_bank == BANK_W'(b))),
      .row_i(cur_row), .idx_i(cur_idx),
      .busy_o(bank_busy[b]), .fin_o(bank_fin[b]),
      .data_o(bank_data[b]), .idx_o(bank_idx[b])
    );
  end

  sbl_return #(.NB(NB), .DATA_W(DATA_W), .VLEN_W(VLEN_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .fin_i(bank_fin), .data_i(bank_data),
    .idx_i(bank_idx), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_idx_o(rd_idx_o)
  );
endmodule

// File: rtl/stride_bank_loader_chk.sv
module stride_bank_loader_chk #(
  parameter int ADDR_W = 10,
  parameter int VLEN_W = 7,
  parameter int BANK_W = 4,
  parameter int LAT    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] stride_i,
  input logic              busy_o,
  input logic              issue_valid_o,
  input logic [ADDR_W-1:0] issue_addr_o,
  input logic              rd_valid_o,
  input logic [VLEN_W-1:0] rd_idx_o,
  input logic              done_o,
  input logic [(1<<BANK_W)-1:0] bank_fin
);
  localparam int NB  = 1 << BANK_W;
  localparam int GW  = $clog2(LAT + 1);

  logic [ADDR_W-1:0] base_c, stride_c, last_addr;
  logic [VLEN_W-1:0] last_idx;
  logic              seen_iss, seen_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_c <= '0; stride_c <= '0; last_addr <= '0; last_idx <= '0;
      seen_iss <= 1'b0; seen_ret <= 1'b0;
    end else begin
      if (start_i && !busy_o) begin
        base_c <= base_i; stride_c <= stride_i;
        seen_iss <= 1'b0; seen_ret <= 1'b0;
      end else begin
        if (issue_valid_o) begin seen_iss <= 1'b1; last_addr <= issue_addr_o; end
        if (rd_valid_o)    begin seen_ret <= 1'b1; last_idx  <= rd_idx_o;     end
      end
    end
  end

  p_stride_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && seen_iss) |-> issue_addr_o == ADDR_W'(last_addr + stride_c));
  p_first_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && !seen_iss) |-> issue_addr_o == base_c);
  p_single_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_fin));
  p_return_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && seen_ret) |-> rd_idx_o == VLEN_W'(last_idx + 1'b1));
  p_first_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !seen_ret) |-> rd_idx_o == '0);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !issue_valid_o);

  for (genvar b = 0; b < NB; b++) begin : g_gap
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
      if (!rst_n) gap <= GW'(LAT);
      else if (issue_valid_o && issue_addr_o[BANK_W-1:0] == BANK_W'(b)) gap <= GW'(1);
      else if (gap < GW'(LAT)) gap <= gap + 1'b1;
    end
    p_bank_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid_o && issue_addr_o[BANK_W-1:0] == BANK_W'(b)) |-> gap >= GW'(LAT));
  end
endmodule

bind stride_bank_loader stride_bank_loader_chk #(
  .ADDR_W(ADDR_W), .VLEN_W(VLEN_W), .BANK_W(BANK_W), .LAT(LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
  .stride_i(stride_i), .busy_o(busy_o), .issue_valid_o(issue_valid_o),
  .issue_addr_o(issue_addr_o), .rd_valid_o(rd_valid_o), .rd_idx_o(rd_idx_o),
  .done_o(done_o), .bank_fin(bank_fin)
);

// File: tb/stride_bank_loader_test.sv
`timescale 1ns/1ps
module stride_bank_loader_test;
  localparam int ADDR_W = 10, DATA_W = 16, VLEN_W = 7, BANK_W = 4, LAT = 11;
  localparam int AMASK = (1 << ADDR_W) - 1;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [ADDR_W-1:0] base_i = '0, stride_i = '0;
  logic [VLEN_W-1:0] vlen_i = '0;
  logic busy_o, issue_valid_o, rd_valid_o, done_o;
  logic [ADDR_W-1:0] issue_addr_o;
  logic [VLEN_W-1:0] rd_idx_o;
  logic [DATA_W-1:0] rd_data_o;

  stride_bank_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VLEN_W(VLEN_W),
    .BANK_W(BANK_W), .LAT(LAT)) uut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int iss_addr[128], iss_cyc[128], rd_idx_a[128], rd_dat[128], rd_cyc[128];
  int n_iss, n_rd, n_done, done_cyc, done_busy;

  always @(negedge clk) if (rst_n) begin
    if (issue_valid_o && n_iss < 128) begin
      iss_addr[n_iss] = int'(issue_addr_o); iss_cyc[n_iss] = cyc; n_iss++;
    end
    if (rd_valid_o && n_rd < 128) begin
      rd_idx_a[n_rd] = int'(rd_idx_o); rd_dat[n_rd] = int'(rd_data_o);
      rd_cyc[n_rd] = cyc; n_rd++;
    end
    if (done_o) begin n_done++; done_cyc = cyc; done_busy = int'(busy_o); end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int word_at(int a);
    return (a * 40503 + 4660) & ((1 << DATA_W) - 1);
  endfunction

  task automatic run(int base, int stride, int vlen, bit disturb);
    int s, t, b, e_addr[128], e_iss[128], free_at[16], wait_n;
    int bad_a, bad_t, bad_r, bad_d;
    for (int k = 0; k < 16; k++) free_at[k] = 0;
    @(negedge clk);
    n_iss = 0; n_rd = 0; n_done = 0; done_cyc = -1; done_busy = -1;
    base_i = ADDR_W'(base); stride_i = ADDR_W'(stride); vlen_i = VLEN_W'(vlen);
    start_i = 1; s = cyc;
    @(negedge clk); start_i = 0;
    if (disturb) begin
      repeat (2) @(negedge clk);
      base_i = ADDR_W'(base + 77); stride_i = ADDR_W'(stride + 5); vlen_i = VLEN_W'(3);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    wait_n = 0;
    while (n_done == 0 && wait_n < 3000) begin @(negedge clk); wait_n++; end
    repeat (4) @(negedge clk);
    if (n_done == 0) begin chk(0, "R7 done timeout", 0, 1); return; end
    // model
    t = s;
    for (int i = 0; i < vlen; i++) begin
      e_addr[i] = (base + i * stride) & AMASK;
      b = e_addr[i] & 15;
      t = t + 1;
      if (t < free_at[b]) t = free_at[b];
      free_at[b] = t + LAT;
      e_iss[i] = t;
    end
    bad_a = 0; bad_t = 0; bad_r = 0; bad_d = 0;
    for (int i = 0; i < vlen && i < n_iss; i++) begin
      if (iss_addr[i] != e_addr[i]) bad_a++;
      if (iss_cyc[i] != e_iss[i]) bad_t++;
    end
    for (int i = 0; i < vlen && i < n_rd; i++) begin
      if (rd_idx_a[i] != i || rd_cyc[i] != e_iss[i] + LAT) bad_r++;
      if (rd_dat[i] != word_at(e_addr[i])) bad_d++;
    end
    chk(n_iss == vlen, vlen == 0 ? "R8 no issue on zero length" : "R2 issue count", n_iss, vlen);
    chk(bad_a == 0, disturb ? "R9 address sequence kept" : "R2 address sequence", bad_a, 0);
    chk(bad_t == 0, stride % 16 == 0 ? "R3 same-bank spacing" : "R4 issue schedule", bad_t, 0);
    chk(n_rd == vlen && bad_r == 0, "R5 return count, order and latency", n_rd - bad_r, vlen);
    chk(bad_d == 0, "R6 returned data", bad_d, 0);
    chk(n_done == 1 && done_busy == 0 &&
        done_cyc == (vlen == 0 ? s + 1 : e_iss[vlen-1] + LAT + 1),
        vlen == 0 ? "R8 done after zero-length start" : "R7 done timing", done_cyc,
        vlen == 0 ? s + 1 : e_iss[vlen-1] + LAT + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !issue_valid_o && !rd_valid_o && !done_o, "R1 reset state",
        int'({busy_o, issue_valid_o, rd_valid_o, done_o}), 0);
    begin
      int strides[16] = '{0, 1, 2, 3, 4, 5, 7, 8, 15, 16, 17, 31, 32, 33, 1023, 1008};
      int vlens[4] = '{1, 7, 16, 23};
      foreach (strides[i])
        foreach (vlens[j]) begin
          run(0, strides[i], vlens[j], 0);
          run(1000, strides[i], vlens[j], 0);
        end
    end
    run(5, 1, 64, 0);     // R4 unit stride, one per cycle
    run(3, 16, 20, 0);    // R3 one per LAT cycles
    run(100, 3, 127, 0);
    run(8, 0, 0, 0);      // R8
    run(12, 1, 30, 1);    // R9
    run(40, 16, 6, 1);    // R9 during stall
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule